// File: doc/BRIEF.md
# Interrupt Aggregation and Routing Controller

This block gathers interrupt events from eight on-chip sources into one sticky status register and exposes that register, together with a mask, a routing register and a small control register, to a microcontroller over a simple byte-wide register bus. Every status bit that is both unmasked and pending drives one of two active-high interrupt outputs. The routing register picks the output for each source. Software can raise any status bit by writing it, and it clears bits through a separate write-one-to-clear address.

Two sources are qualified inside the block. The DMA source is taken from the falling edge of a transfer-in-progress input and is gated by a DMA interrupt enable. A sticky end-of-transfer flag records every such edge, whatever the enable. The protocol-core source combines a generic core event with two qualified conditions: a parity error, which counts only when two separate enables are both set, and an unexpected loss of the bus busy line, which counts only when busy monitoring is enabled. A sticky request-active flag records that an interrupt output has been asserted. Any read of the flags register clears it.

Top module: `irq_route_ctrl`

## Requirements
- R1: A status bit sets on its source event and stays set until a 1 is written to the same bit at the clear address (0x1). If a clear and an event hit the same bit in the same cycle, the bit stays set.
- R2: Writing the status address (0x0) sets every status bit written as 1. Bits written as 0 keep their value.
- R3: The mask register (0x2) resets to 0x00. A 0 bit keeps its pending status bit off both outputs, and a 1 bit lets it through.
- R4: Routing register (0x3) bit n = 0 sends status bit n to `irq_a_o`, and 1 sends it to `irq_b_o`. Each output is registered. It rises on the clock edge after the edge that sets the status bit.
- R5: Status bit 4 sets on a 1-to-0 transition of `dma_tip_i` only when control bit 0 (DMA interrupt enable) is 1.
- R6: A `parity_err_i` pulse sets status bit 7 only when control bit 1 (parity interrupt enable) and control bit 2 (parity checking enable) are both 1.
- R7: With control bit 3 (busy monitor enable) set, a 1-to-0 transition of `busy_i` while `busy_rel_ok_i` is low sets status bit 7. An expected release (`busy_rel_ok_i` high) or a cleared enable raises nothing.
- R8: Flags bit 1 (end of transfer) sets on every 1-to-0 transition of `dma_tip_i`, whatever the enable. Writing 1 to flags bit 1 clears it, and a new edge in the same cycle wins.
- R9: Flags bit 0 (request active) sets in any cycle in which either interrupt output is high. A read of the flags address (0x5) returns the value from before the read and then clears the bit, unless an output is high in that cycle.
- R10: A read issued with `bus_rd_i` returns its data on `bus_rdata_o` after the next clock edge. Addresses: 0x0 status, 0x1 clear (reads 0), 0x2 mask, 0x3 routing, 0x4 control (bits 3:0), 0x5 flags (bits 1:0). Other addresses read 0.
- R11: Status bit positions: bits 1:0 are the two port lines, bits 3:2 the two timers, bit 4 DMA, bits 6:5 the two serial interfaces, and bit 7 the protocol core (including `core_evt_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_evt_i | input | 2 | Port line event pulses |
| tmr_evt_i | input | 2 | Timer event pulses |
| ser_evt_i | input | 2 | Serial interface event pulses |
| core_evt_i | input | 1 | Generic protocol-core event pulse |
| dma_tip_i | input | 1 | DMA transfer-in-progress level |
| parity_err_i | input | 1 | Protocol-core parity error pulse |
| busy_i | input | 1 | Bus busy line level |
| busy_rel_ok_i | input | 1 | High when a busy release is expected |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, one cycle after the strobe |
| irq_a_o | output | 1 | Interrupt output A |
| irq_b_o | output | 1 | Interrupt output B |

## Verification
The bench sends a clear and a new event to the same bit in one cycle. A design that lets the clear win loses that interrupt. It drops `dma_tip_i` with the DMA enable both off and on, and checks that the end-of-transfer flag sets in both cases while the status bit sets only with the enable on. A design that ties the two together fails one of those reads. It raises parity errors with only one of the two enables set, and drops the busy line during an expected release. A design that does not qualify these conditions sets bit 7 where it should stay clear. It reads the flags register twice while an output is held high, and twice after the outputs fall. Wrong clear priority or wrong read latency shows up there as a mismatched flag.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int NSRC   = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    localparam int SRC_PORT0 = 0;
    localparam int SRC_PORT1 = 1;
    localparam int SRC_TMR0  = 2;
    localparam int SRC_TMR1  = 3;
    localparam int SRC_DMA   = 4;
    localparam int SRC_SER0  = 5;
    localparam int SRC_SER1  = 6;
    localparam int SRC_CORE  = 7;

    localparam int NFALL     = 2;
    localparam int FALL_DMA  = 0;
    localparam int FALL_BUSY = 1;

    typedef logic [NSRC-1:0]   src_vec_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT  = 4'h0,
        REG_CLR   = 4'h1,
        REG_MASK  = 4'h2,
        REG_DEST  = 4'h3,
        REG_CTRL  = 4'h4,
        REG_FLAGS = 4'h5
    } reg_addr_e;

    typedef struct packed {
        logic mon_busy_en;
        logic par_chk_en;
        logic par_irq_en;
        logic dma_ien;
    } ctrl_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        data_t             wdata;
    } bus_req_t;

    typedef struct packed {
        logic dma_done;
        logic req_active;
    } flags_t;

    function automatic data_t ctrl_to_data(ctrl_t c);
        data_t d;
        d = '0;
        d[$bits(ctrl_t)-1:0] = c;
        return d;
    endfunction

    function automatic data_t flags_to_data(flags_t f);
        data_t d;
        d = '0;
        d[$bits(flags_t)-1:0] = f;
        return d;
    endfunction

    function automatic logic hits(bus_req_t r, reg_addr_e a);
        return r.addr == a;
    endfunction

endpackage

// File: rtl/irq_fall_det.sv
module irq_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic fall_o
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level_i;
    end

    assign fall_o = level_q & ~level_i;

    AST_FALL_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        fall_o |-> $past(level_i)); // R5
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
    import irq_route_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic [1:0] port_evt_i,
    input  logic [1:0] tmr_evt_i,
    input  logic [1:0] ser_evt_i,
    input  logic     core_evt_i,
    input  logic     dma_tip_i,
    input  logic     parity_err_i,
    input  logic     busy_i,
    input  logic     busy_rel_ok_i,
    input  ctrl_t    ctrl_i,
    output src_vec_t evt_o,
    output logic     dma_fall_o
);
    logic [NFALL-1:0] levels;
    logic [NFALL-1:0] falls;
    logic             par_hit;
    logic             busy_hit;

    assign levels[FALL_DMA]  = dma_tip_i;
    assign levels[FALL_BUSY] = busy_i;

    for (genvar g = 0; g < NFALL; g++) begin : g_fall
        irq_fall_det u_fall (
            .clk     (clk),
            .rst     (rst),
            .level_i (levels[g]),
            .fall_o  (falls[g])
        );
    end

    assign dma_fall_o = falls[FALL_DMA];
    assign par_hit    = parity_err_i & ctrl_i.par_irq_en & ctrl_i.par_chk_en;
    assign busy_hit   = falls[FALL_BUSY] & ~busy_rel_ok_i & ctrl_i.mon_busy_en;

    always_comb begin
        evt_o            = '0;
        evt_o[SRC_PORT0] = port_evt_i[0];
        evt_o[SRC_PORT1] = port_evt_i[1];
        evt_o[SRC_TMR0]  = tmr_evt_i[0];
        evt_o[SRC_TMR1]  = tmr_evt_i[1];
        evt_o[SRC_DMA]   = falls[FALL_DMA] & ctrl_i.dma_ien;
        evt_o[SRC_SER0]  = ser_evt_i[0];
        evt_o[SRC_SER1]  = ser_evt_i[1];
        evt_o[SRC_CORE]  = core_evt_i | par_hit | busy_hit;
    end

    AST_DMA_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.dma_ien |-> !evt_o[SRC_DMA]); // R5
    AST_PAR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (!core_evt_i && !ctrl_i.mon_busy_en && !(ctrl_i.par_irq_en && ctrl_i.par_chk_en))
        |-> !evt_o[SRC_CORE]); // R6
    AST_BUSY_EXPECTED: assert property (@(posedge clk) disable iff (rst)
        (!core_evt_i && busy_rel_ok_i && !parity_err_i) |-> !evt_o[SRC_CORE]); // R7
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_route_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt_i,
    input  src_vec_t force_i,
    input  src_vec_t clr_i,
    input  src_vec_t mask_i,
    input  src_vec_t dest_i,
    output src_vec_t stat_o,
    output logic     irq_a_o,
    output logic     irq_b_o
);
    src_vec_t stat_q;
    src_vec_t live;
    logic     irq_a_q;
    logic     irq_b_q;

    for (genvar n = 0; n < NSRC; n++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                stat_q[n] <= 1'b0;
            else if (evt_i[n] || force_i[n])
                stat_q[n] <= 1'b1;
            else if (clr_i[n])
                stat_q[n] <= 1'b0;
        end
    end

    assign live = stat_q & mask_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_a_q <= 1'b0;
            irq_b_q <= 1'b0;
        end else begin
            irq_a_q <= |(live & ~dest_i);
            irq_b_q <= |(live & dest_i);
        end
    end

    assign stat_o  = stat_q;
    assign irq_a_o = irq_a_q;
    assign irq_b_o = irq_b_q;

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat_q) & ~$past(clr_i) & ~stat_q) == '0)); // R1
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(evt_i) & ~stat_q) == '0)); // R1
    AST_FORCE_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(force_i) & ~stat_q) == '0)); // R2
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (mask_i == '0) |=> (!irq_a_o && !irq_b_o)); // R3
endmodule

// File: rtl/irq_regif.sv
module irq_regif
    import irq_route_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req_i,
    input  src_vec_t stat_i,
    input  logic     irq_a_i,
    input  logic     irq_b_i,
    input  logic     dma_fall_i,
    output src_vec_t mask_o,
    output src_vec_t dest_o,
    output ctrl_t    ctrl_o,
    output src_vec_t force_o,
    output src_vec_t clr_o,
    output data_t    rdata_o
);
    src_vec_t mask_q;
    src_vec_t dest_q;
    ctrl_t    ctrl_q;
    flags_t   flags_q;
    data_t    rdata_q;
    logic     wr_stat, wr_clr, wr_mask, wr_dest, wr_ctrl, wr_flags;
    logic     rd_flags;
    logic     any_irq;

    assign wr_stat  = req_i.wr & hits(req_i, REG_STAT);
    assign wr_clr   = req_i.wr & hits(req_i, REG_CLR);
    assign wr_mask  = req_i.wr & hits(req_i, REG_MASK);
    assign wr_dest  = req_i.wr & hits(req_i, REG_DEST);
    assign wr_ctrl  = req_i.wr & hits(req_i, REG_CTRL);
    assign wr_flags = req_i.wr & hits(req_i, REG_FLAGS);
    assign rd_flags = req_i.rd & hits(req_i, REG_FLAGS);
    assign any_irq  = irq_a_i | irq_b_i;

    assign force_o = wr_stat ? req_i.wdata : '0;
    assign clr_o   = wr_clr  ? req_i.wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            dest_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_mask) mask_q <= req_i.wdata;
            if (wr_dest) dest_q <= req_i.wdata;
            if (wr_ctrl) ctrl_q <= ctrl_t'(req_i.wdata[$bits(ctrl_t)-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.req_active <= any_irq | (flags_q.req_active & ~rd_flags);
            if (dma_fall_i)
                flags_q.dma_done <= 1'b1;
            else if (wr_flags && req_i.wdata[1])
                flags_q.dma_done <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req_i.rd) begin
            case (req_i.addr)
                REG_STAT:  rdata_q <= stat_i;
                REG_MASK:  rdata_q <= mask_q;
                REG_DEST:  rdata_q <= dest_q;
                REG_CTRL:  rdata_q <= ctrl_to_data(ctrl_q);
                REG_FLAGS: rdata_q <= flags_to_data(flags_q);
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign mask_o  = mask_q;
    assign dest_o  = dest_q;
    assign ctrl_o  = ctrl_q;
    assign rdata_o = rdata_q;

    AST_REQ_ACT_SETS: assert property (@(posedge clk) disable iff (rst)
        any_irq |=> flags_q.req_active); // R9
    AST_REQ_ACT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_flags && !any_irq) |=> !flags_q.req_active); // R9
    AST_DMA_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
        dma_fall_i |=> flags_q.dma_done); // R8
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !req_i.rd |=> $stable(rdata_q)); // R10
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  port_evt_i,
    input  logic [1:0]  tmr_evt_i,
    input  logic [1:0]  ser_evt_i,
    input  logic        core_evt_i,
    input  logic        dma_tip_i,
    input  logic        parity_err_i,
    input  logic        busy_i,
    input  logic        busy_rel_ok_i,
    input  logic        bus_wr_i,
    input  logic        bus_rd_i,
    input  logic [3:0]  bus_addr_i,
    input  logic [7:0]  bus_wdata_i,
    output logic [7:0]  bus_rdata_o,
    output logic        irq_a_o,
    output logic        irq_b_o
);
    bus_req_t req;
    ctrl_t    ctrl;
    src_vec_t evt, force_v, clr_v, mask_v, dest_v, stat_v;
    logic     dma_fall;
    logic     irq_a, irq_b;
    data_t    rdata;

    assign req.wr    = bus_wr_i;
    assign req.rd    = bus_rd_i;
    assign req.addr  = bus_addr_i;
    assign req.wdata = bus_wdata_i;

    irq_src_cond u_cond (
        .clk           (clk),
        .rst           (rst),
        .port_evt_i    (port_evt_i),
        .tmr_evt_i     (tmr_evt_i),
        .ser_evt_i     (ser_evt_i),
        .core_evt_i    (core_evt_i),
        .dma_tip_i     (dma_tip_i),
        .parity_err_i  (parity_err_i),
        .busy_i        (busy_i),
        .busy_rel_ok_i (busy_rel_ok_i),
        .ctrl_i        (ctrl),
        .evt_o         (evt),
        .dma_fall_o    (dma_fall)
    );

    irq_status_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .force_i (force_v),
        .clr_i   (clr_v),
        .mask_i  (mask_v),
        .dest_i  (dest_v),
        .stat_o  (stat_v),
        .irq_a_o (irq_a),
        .irq_b_o (irq_b)
    );

    irq_regif u_regs (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .stat_i     (stat_v),
        .irq_a_i    (irq_a),
        .irq_b_i    (irq_b),
        .dma_fall_i (dma_fall),
        .mask_o     (mask_v),
        .dest_o     (dest_v),
        .ctrl_o     (ctrl),
        .force_o    (force_v),
        .clr_o      (clr_v),
        .rdata_o    (rdata)
    );

    assign bus_rdata_o = rdata;
    assign irq_a_o     = irq_a;
    assign irq_b_o     = irq_b;

    AST_ROUTED_A: assert property (@(posedge clk) disable iff (rst)
        ((stat_v & mask_v & ~dest_v) != '0) |=> irq_a_o); // R4
    AST_ROUTED_B: assert property (@(posedge clk) disable iff (rst)
        ((stat_v & mask_v & dest_v) == '0) |=> !irq_b_o); // R4
endmodule

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] port_evt = '0, tmr_evt = '0, ser_evt = '0;
    logic       core_evt = 0, dma_tip = 0, parity_err = 0, busy = 0, busy_rel_ok = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_a, irq_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    irq_route_ctrl uut (
        .clk(clk), .rst(rst),
        .port_evt_i(port_evt), .tmr_evt_i(tmr_evt), .ser_evt_i(ser_evt),
        .core_evt_i(core_evt), .dma_tip_i(dma_tip), .parity_err_i(parity_err),
        .busy_i(busy), .busy_rel_ok_i(busy_rel_ok),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_a_o(irq_a), .irq_b_o(irq_b)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference model
    bit [7:0] m_stat, m_mask, m_dest, m_rdata;
    bit [3:0] m_ctrl;
    bit       m_irq_a, m_irq_b, m_req, m_done, m_tip_prev, m_busy_prev;

    always @(posedge clk) begin
        bit [7:0] ev, nstat, nrd;
        bit na, nb, nreq, ndone, tip_fall, busy_fall;
        if (rst) begin
            m_stat = 0; m_mask = 0; m_dest = 0; m_rdata = 0; m_ctrl = 0;
            m_irq_a = 0; m_irq_b = 0; m_req = 0; m_done = 0;
            m_tip_prev = 0; m_busy_prev = 0;
        end else begin
            tip_fall  = m_tip_prev && !dma_tip;
            busy_fall = m_busy_prev && !busy;
            ev = {1'b0, ser_evt, 1'b0, tmr_evt, port_evt};
            if (tip_fall && m_ctrl[0]) ev[4] = 1;
            if (core_evt) ev[7] = 1;
            if (parity_err && m_ctrl[1] && m_ctrl[2]) ev[7] = 1;
            if (busy_fall && !busy_rel_ok && m_ctrl[3]) ev[7] = 1;
            nstat = m_stat;
            for (int i = 0; i < 8; i++) begin
                if (bus_wr && bus_addr == 1 && bus_wdata[i]) nstat[i] = 0;
                if (ev[i]) nstat[i] = 1;
                if (bus_wr && bus_addr == 0 && bus_wdata[i]) nstat[i] = 1;
            end
            na = 0; nb = 0;
            for (int i = 0; i < 8; i++)
                if (m_stat[i] && m_mask[i]) begin
                    if (m_dest[i]) nb = 1; else na = 1;
                end
            nreq = m_req;
            if (bus_rd && bus_addr == 5) nreq = 0;
            if (m_irq_a || m_irq_b) nreq = 1;
            ndone = m_done;
            if (bus_wr && bus_addr == 5 && bus_wdata[1]) ndone = 0;
            if (tip_fall) ndone = 1;
            nrd = m_rdata;
            if (bus_rd) begin
                case (bus_addr)
                    0: nrd = m_stat;
                    2: nrd = m_mask;
                    3: nrd = m_dest;
                    4: nrd = {4'b0, m_ctrl};
                    5: nrd = {6'b0, m_done, m_req};
                    default: nrd = 0;
                endcase
            end
            if (bus_wr && bus_addr == 2) m_mask = bus_wdata;
            if (bus_wr && bus_addr == 3) m_dest = bus_wdata;
            if (bus_wr && bus_addr == 4) m_ctrl = bus_wdata[3:0];
            m_stat = nstat; m_irq_a = na; m_irq_b = nb; m_req = nreq;
            m_done = ndone; m_rdata = nrd;
            m_tip_prev = dma_tip; m_busy_prev = busy;
        end
    end

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    always begin
        @(posedge clk);
        #1;
        if (!done) begin
            check("R4 irq_a vs model", irq_a, m_irq_a);
            check("R4 irq_b vs model", irq_b, m_irq_b);
            check("R10 rdata vs model", bus_rdata, m_rdata);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_wr = 1; bus_addr = 4'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(int a, output int d);
        @(negedge clk);
        bus_rd = 1; bus_addr = 4'(a);
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic expect_reg(string tag, int a, int msk, int exp);
        int d;
        rd(a, d);
        check(tag, d & msk, exp);
    endtask

    task automatic tip_drop();
        @(negedge clk); dma_tip = 1;
        @(negedge clk); dma_tip = 0;
        idle(1);
    endtask

    task automatic busy_drop(bit rel_ok);
        @(negedge clk); busy = 1; busy_rel_ok = rel_ok;
        @(negedge clk); busy = 0;
        @(negedge clk); busy_rel_ok = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        check("R3 reset irq_a", irq_a, 0);
        check("R3 reset irq_b", irq_b, 0);
        expect_reg("R3 mask reset", 2, 8'hFF, 8'h00);
        expect_reg("R1 status reset", 0, 8'hFF, 8'h00);

        @(negedge clk); port_evt = 2'b01; @(negedge clk); port_evt = 0;
        expect_reg("R11 port0 bit", 0, 8'hFF, 8'h01);
        idle(2);
        check("R3 masked output", irq_a, 0);

        wr(2, 8'hFF); wr(3, 8'h00); idle(3);
        check("R4 routed to A", irq_a, 1);
        check("R4 not on B", irq_b, 0);

        @(negedge clk);
        bus_wr = 1; bus_addr = 4'h1; bus_wdata = 8'h01; port_evt = 2'b01;
        @(negedge clk);
        bus_wr = 0; port_evt = 0;
        expect_reg("R1 event beats clear", 0, 8'hFF, 8'h01);
        wr(1, 8'h01);
        expect_reg("R1 w1c clears", 0, 8'hFF, 8'h00);
        idle(3);
        check("R4 output drops", irq_a, 0);

        wr(0, 8'h22);
        expect_reg("R2 force bits", 0, 8'hFF, 8'h22);
        wr(0, 8'h00);
        expect_reg("R2 zero force no effect", 0, 8'hFF, 8'h22);
        wr(3, 8'h20); idle(3);
        check("R4 bit1 to A", irq_a, 1);
        check("R4 bit5 to B", irq_b, 1);
        wr(2, 8'h02); idle(3);
        check("R3 mask blocks B", irq_b, 0);
        check("R3 mask passes A", irq_a, 1);
        wr(1, 8'hFF); wr(2, 8'hFF); idle(3);

        @(negedge clk); tmr_evt = 2'b10; @(negedge clk); tmr_evt = 0;
        expect_reg("R11 timer1 bit3", 0, 8'hFF, 8'h08);
        @(negedge clk); ser_evt = 2'b01; @(negedge clk); ser_evt = 0;
        expect_reg("R11 serial0 bit5", 0, 8'hFF, 8'h28);
        @(negedge clk); port_evt = 2'b10; @(negedge clk); port_evt = 0;
        expect_reg("R11 port1 bit1", 0, 8'hFF, 8'h2A);
        @(negedge clk); core_evt = 1; @(negedge clk); core_evt = 0;
        expect_reg("R11 core bit7", 0, 8'hFF, 8'hAA);
        wr(1, 8'hFF);

        wr(4, 8'h00); tip_drop();
        expect_reg("R5 dma disabled", 0, 8'hFF, 8'h00);
        expect_reg("R8 done without enable", 5, 8'h02, 8'h02);
        wr(5, 8'h02);
        expect_reg("R8 done cleared", 5, 8'h02, 8'h00);
        wr(4, 8'h01); tip_drop();
        expect_reg("R5 dma enabled", 0, 8'hFF, 8'h10);
        wr(1, 8'hFF);

        wr(4, 8'h02);
        @(negedge clk); parity_err = 1; @(negedge clk); parity_err = 0;
        expect_reg("R6 parity irq only", 0, 8'hFF, 8'h00);
        wr(4, 8'h04);
        @(negedge clk); parity_err = 1; @(negedge clk); parity_err = 0;
        expect_reg("R6 parity check only", 0, 8'hFF, 8'h00);
        wr(4, 8'h06);
        @(negedge clk); parity_err = 1; @(negedge clk); parity_err = 0;
        expect_reg("R6 parity both", 0, 8'hFF, 8'h80);
        wr(1, 8'hFF);

        wr(4, 8'h08); busy_drop(1);
        expect_reg("R7 expected release", 0, 8'hFF, 8'h00);
        busy_drop(0);
        expect_reg("R7 unexpected loss", 0, 8'hFF, 8'h80);
        wr(1, 8'hFF);
        wr(4, 8'h00); busy_drop(0);
        expect_reg("R7 monitor off", 0, 8'hFF, 8'h00);
        idle(3);

        expect_reg("R9 active after irq", 5, 8'h01, 8'h01);
        expect_reg("R9 cleared by read", 5, 8'h01, 8'h00);
        wr(0, 8'h01); idle(3);
        expect_reg("R9 held while irq", 5, 8'h01, 8'h01);
        expect_reg("R9 read cannot clear", 5, 8'h01, 8'h01);
        wr(1, 8'hFF); idle(3);

        expect_reg("R10 unmapped", 7, 8'hFF, 8'h00);
        expect_reg("R10 clear reads 0", 1, 8'hFF, 8'h00);
        expect_reg("R10 mask readback", 2, 8'hFF, 8'hFF);
        wr(4, 8'hFB);
        expect_reg("R10 ctrl readback", 4, 8'hFF, 8'h0B);
        idle(4);
        finish_run();
    end
endmodule